// File: doc/BRIEF.md
# SIMD Floating-Point Minimum/Maximum Unit

This block takes two 128-bit vectors and returns their lane-wise minimum or maximum. A per-operation select treats the vectors either as four IEEE-754 single-precision lanes or as two double-precision lanes. The result is held in a register, and a valid strobe follows the request by one clock cycle.

A run-time policy input sets how NaN operands and a pair of signed zeros are resolved. Three conventions are available:
- a number-preferring rule, where a lone NaN gives way to the number and -0 orders below +0;
- a NaN-propagating rule, where any NaN operand produces a quiet NaN;
- an operand-order rule, where NaN inputs and zero pairs always return the second operand.

Whatever the policy, a signaling NaN on any active lane sets a sticky invalid-operation flag. That flag stays set until a synchronous clear.

Ordering does not need a floating-point subtractor. Each operand is mapped to an unsigned key whose integer order matches the numeric order, and the two keys are compared as integers.

Top module: `vfminmax_unit`

## Requirements
- R1: The result register and `res_vld` update on the clock edge that samples `in_vld` high, so both are visible one cycle later. When `in_vld` is low, `res` keeps its value and `res_vld` is low in the next cycle.
- R2: When `dbl` is 0, lane i is bits [32i+31:32i], for i = 0..3, each holding a single-precision value. When `dbl` is 1, lane j is bits [64j+63:64j], for j = 0..1, each holding a double-precision value. NaN and signaling-NaN detection use only the active lane format.
- R3: When neither operand of a lane is NaN and the two are not both zeros, the lane returns the numerically smaller value (`sel_max`=0) or the larger value (`sel_max`=1), under every policy.
- R4: Under policy 0 and policy 3 (number-preferring), -0 orders below +0. So min(+0,-0) is -0 and max(+0,-0) is +0.
- R5: Under the number-preferring policies, a lane where exactly one operand is NaN returns the other operand.
- R6: Under the number-preferring policies, a lane where both operands are NaN returns the canonical NaN. This is 32'h7FC00000 for single precision and 64'h7FF8000000000000 for double precision.
- R7: Under policy 1 (NaN-propagating), a lane with a NaN operand returns the first NaN operand, taking `op_a` before `op_b`. The top mantissa bit (the quiet bit) is forced to 1 and the payload is kept. Zero pairs order -0 below +0.
- R8: Under policy 2 (operand-order), a lane returns `op_b` whenever either operand is NaN or both operands are zeros of any sign.
- R9: A signaling NaN has an all-ones exponent, a clear top mantissa bit and a nonzero mantissa. One on any active lane of either operand, while `in_vld` is high, sets `inv_flag` one cycle later under every policy, even when the returned value is a number.
- R10: `inv_flag` stays set until `clr_inv` is sampled high. A clear cycle without a new signaling NaN leaves it low. A new signaling NaN in the clear cycle leaves it set.
- R11: While `rst` is high at a clock edge, `res`, `res_vld` and `inv_flag` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operation request strobe |
| op_a | input | 128 | First operand vector |
| op_b | input | 128 | Second operand vector |
| dbl | input | 1 | 1 selects two 64-bit lanes, 0 selects four 32-bit lanes |
| sel_max | input | 1 | 1 selects maximum, 0 selects minimum |
| policy | input | 2 | 0/3 number-preferring, 1 NaN-propagating, 2 operand-order |
| clr_inv | input | 1 | Synchronous clear of the invalid flag |
| res | output | 128 | Registered result vector |
| res_vld | output | 1 | Result valid, one cycle after `in_vld` |
| inv_flag | output | 1 | Sticky invalid-operation flag |

## Verification
The bench builds the unit with its default parameters: a 128-bit vector, single precision as 8/23 exponent/mantissa bits and double precision as 11/52. With these values both the four-lane and the two-lane layouts are reachable in one run. The table mixes lanes that differ by sign, zero sign, quiet NaN and payload, so each policy is exercised in both formats. One directed case places a single-precision signaling-NaN pattern inside a double lane, where it is not a NaN, and checks that the flag stays clear.

// File: rtl/vfmm_pkg.sv
package vfmm_pkg;
  localparam logic [1:0] POL_NUM     = 2'd0;
  localparam logic [1:0] POL_NANPROP = 2'd1;
  localparam logic [1:0] POL_ORDER   = 2'd2;
  localparam logic [1:0] POL_NUM_ALT = 2'd3;
endpackage

// File: rtl/vfmm_lane.sv
module vfmm_lane #(
  parameter int EW = 8,
  parameter int MW = 23
) (
  input  logic [EW+MW:0] a,
  input  logic [EW+MW:0] b,
  input  logic           sel_max,
  input  logic [1:0]     policy,
  output logic [EW+MW:0] r,
  output logic           snan
);
  import vfmm_pkg::*;
  localparam int W = 1 + EW + MW;
  localparam logic [W-1:0] CANON = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};
  localparam logic [W-1:0] QBIT  = {{(EW+1){1'b0}}, 1'b1, {(MW-1){1'b0}}};

  function automatic logic [W-1:0] order_key(input logic [W-1:0] x);
    order_key = x[W-1] ? ~x : {1'b1, x[W-2:0]};
  endfunction

  logic a_nan, b_nan, a_zero, b_zero, a_lt;
  logic [W-1:0] ordinary;

  always_comb begin
    a_nan  = (&a[W-2:MW]) && (|a[MW-1:0]);
    b_nan  = (&b[W-2:MW]) && (|b[MW-1:0]);
    a_zero = ~|a[W-2:0];
    b_zero = ~|b[W-2:0];
    snan   = (a_nan && !a[MW-1]) || (b_nan && !b[MW-1]);
    a_lt   = order_key(a) < order_key(b);
    if (sel_max) ordinary = a_lt ? b : a;
    else         ordinary = a_lt ? a : b;
    case (policy)
      POL_NANPROP: begin
        if (a_nan)      r = a | QBIT;
        else if (b_nan) r = b | QBIT;
        else            r = ordinary;
      end
      POL_ORDER: begin
        if (a_nan || b_nan || (a_zero && b_zero)) r = b;
        else                                      r = ordinary;
      end
      default: begin
        if (a_nan && b_nan) r = CANON;
        else if (a_nan)     r = b;
        else if (b_nan)     r = a;
        else                r = ordinary;
      end
    endcase
  end
endmodule

// File: rtl/vfmm_sticky.sv
module vfmm_sticky (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= (q && !clr) || set;
  end
endmodule

// File: rtl/vfminmax_unit.sv
module vfminmax_unit #(
  parameter int VW    = 128,
  parameter int SP_EW = 8,
  parameter int SP_MW = 23,
  parameter int DP_EW = 11,
  parameter int DP_MW = 52
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [VW-1:0] op_a,
  input  logic [VW-1:0] op_b,
  input  logic          dbl,
  input  logic          sel_max,
  input  logic [1:0]    policy,
  input  logic          clr_inv,
  output logic [VW-1:0] res,
  output logic          res_vld,
  output logic          inv_flag
);
  localparam int SP_W = 1 + SP_EW + SP_MW;
  localparam int DP_W = 1 + DP_EW + DP_MW;
  localparam int NSP  = VW / SP_W;
  localparam int NDP  = VW / DP_W;

  logic [VW-1:0]  sp_res, dp_res;
  logic [NSP-1:0] sp_snan;
  logic [NDP-1:0] dp_snan;
  logic           any_snan;

  for (genvar i = 0; i < NSP; i++) begin : g_sp
    vfmm_lane #(.EW(SP_EW), .MW(SP_MW)) u_lane (
      .a(op_a[i*SP_W +: SP_W]), .b(op_b[i*SP_W +: SP_W]),
      .sel_max(sel_max), .policy(policy),
      .r(sp_res[i*SP_W +: SP_W]), .snan(sp_snan[i])
    );
  end

  for (genvar j = 0; j < NDP; j++) begin : g_dp
    vfmm_lane #(.EW(DP_EW), .MW(DP_MW)) u_lane (
      .a(op_a[j*DP_W +: DP_W]), .b(op_b[j*DP_W +: DP_W]),
      .sel_max(sel_max), .policy(policy),
      .r(dp_res[j*DP_W +: DP_W]), .snan(dp_snan[j])
    );
  end

  assign any_snan = in_vld && (dbl ? (|dp_snan) : (|sp_snan));

  always_ff @(posedge clk) begin
    if (rst) begin
      res     <= '0;
      res_vld <= 1'b0;
    end else begin
      res_vld <= in_vld;
      if (in_vld) res <= dbl ? dp_res : sp_res;
    end
  end

  vfmm_sticky u_inv (
    .clk(clk), .rst(rst), .clr(clr_inv), .set(any_snan), .q(inv_flag)
  );
endmodule

// File: rtl/vfmm_chk.sv
module vfmm_chk (
  input logic         clk,
  input logic         rst,
  input logic         in_vld,
  input logic [127:0] op_a,
  input logic [127:0] op_b,
  input logic         dbl,
  input logic         sel_max,
  input logic [1:0]   policy,
  input logic         clr_inv,
  input logic [127:0] res,
  input logic         res_vld,
  input logic         inv_flag
);
  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> res_vld);
  // R1
  res_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(res) && !res_vld));
  // R10
  inv_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_flag && !clr_inv) |=> inv_flag);
  // R10
  inv_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_inv && !in_vld) |=> !inv_flag);
  // R6
  dbl_canon_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && dbl && (policy == 2'd0) &&
     (&op_a[62:52]) && (|op_a[51:0]) && (&op_b[62:52]) && (|op_b[51:0]))
    |=> (res[63:0] == 64'h7FF8000000000000));
  // R8
  order_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !dbl && (policy == 2'd2) &&
     (op_a[31:0] == 32'h0) && (op_b[31:0] == 32'h80000000))
    |=> (res[31:0] == 32'h80000000));
  // R9
  snan_set_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !dbl && (&op_a[30:23]) && !op_a[22] && (|op_a[21:0]))
    |=> inv_flag);
endmodule

bind vfminmax_unit vfmm_chk u_chk (.*);

// File: tb/vfminmax_unit_tb.sv
module vfminmax_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_vld = 1'b0;
  logic [127:0] op_a = '0, op_b = '0;
  logic         dbl = 1'b0, sel_max = 1'b0, clr_inv = 1'b0;
  logic [1:0]   policy = 2'd0;
  logic [127:0] res;
  logic         res_vld, inv_flag;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vfminmax_unit u_dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
    .dbl(dbl), .sel_max(sel_max), .policy(policy), .clr_inv(clr_inv),
    .res(res), .res_vld(res_vld), .inv_flag(inv_flag)
  );

  // {dbl, sel_max, policy, op_a, op_b, expected}
  localparam logic [387:0] VEC [0:NV-1] = '{
    // R3 single min
    {1'b0,1'b0,2'd0,128'h3F800000_BF800000_40000000_C0400000,128'h40000000_C0400000_3F800000_BF800000,128'h3F800000_C0400000_3F800000_C0400000},
    // R3 single max under operand-order
    {1'b0,1'b1,2'd2,128'h3F800000_BF800000_40000000_C0400000,128'h40000000_C0400000_3F800000_BF800000,128'h40000000_BF800000_40000000_BF800000},
    // R4 min zeros
    {1'b0,1'b0,2'd0,128'h00000000_80000000_00000000_3F800000,128'h80000000_00000000_00000000_00000000,128'h80000000_80000000_00000000_00000000},
    // R4 max zeros
    {1'b0,1'b1,2'd0,128'h00000000_80000000_00000000_3F800000,128'h80000000_00000000_00000000_00000000,128'h00000000_00000000_00000000_3F800000},
    // R5 R6 single
    {1'b0,1'b0,2'd0,128'h7FC12345_3F800000_7FC12345_40000000,128'h3F800000_7FC00099_FFC00001_C0400000,128'h3F800000_3F800000_7FC00000_C0400000},
    // R7 single max
    {1'b0,1'b1,2'd1,128'h7FC12345_3F800000_7FE00000_00000000,128'h3F800000_FFC00001_7FC00099_80000000,128'h7FC12345_FFC00001_7FE00000_00000000},
    // R8 min
    {1'b0,1'b0,2'd2,128'h7FC12345_3F800000_00000000_80000000,128'h3F800000_7FC00099_80000000_00000000,128'h3F800000_7FC00099_80000000_00000000},
    // R8 max
    {1'b0,1'b1,2'd2,128'h7FC12345_3F800000_00000000_80000000,128'h3F800000_7FC00099_80000000_00000000,128'h3F800000_7FC00099_80000000_00000000},
    // R2 R3 double min
    {1'b1,1'b0,2'd0,128'h40000000_00000000_C0000000_00000000,128'h3FF00000_00000000_3FF00000_00000000,128'h3FF00000_00000000_C0000000_00000000},
    // R2 R6 R5 double max
    {1'b1,1'b1,2'd0,128'h7FF80000_00000ABC_7FF80000_00000ABC,128'h7FF80000_000000DE_40000000_00000000,128'h7FF80000_00000000_40000000_00000000},
    // R7 double min
    {1'b1,1'b0,2'd1,128'h3FF00000_00000000_80000000_00000000,128'h7FF80000_00000ABC_00000000_00000000,128'h7FF80000_00000ABC_80000000_00000000},
    // R4 R5 double, policy 3
    {1'b1,1'b0,2'd3,128'h00000000_00000000_7FF80000_00000ABC,128'h80000000_00000000_C0000000_00000000,128'h80000000_00000000_C0000000_00000000}
  };

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input bit d, input bit m, input logic [1:0] p,
                       input logic [127:0] a, input logic [127:0] b, input bit clr);
    @(negedge clk);
    dbl = d; sel_max = m; policy = p; op_a = a; op_b = b; in_vld = 1'b1; clr_inv = clr;
    @(negedge clk);
    in_vld = 1'b0; clr_inv = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(res == '0 && !res_vld && !inv_flag, "R11 reset", {res_vld, inv_flag, res[125:0]}, '0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][387], VEC[i][386], VEC[i][385:384], VEC[i][383:256], VEC[i][255:128], 1'b0);
      check(res == VEC[i][127:0] && res_vld, $sformatf("R3 R4 R5 R6 R7 R8 vector %0d", i), res, VEC[i][127:0]);
      check(!inv_flag, "R9 no flag on quiet data", {127'd0, inv_flag}, '0);
    end

    // R1 hold when idle
    held = res;
    @(negedge clk);
    op_a = '1; op_b = '0; dbl = 1'b0;
    @(negedge clk);
    check(res == held && !res_vld, "R1 hold", res, held);

    // R9 signaling NaN, number returned
    issue(1'b0, 1'b0, 2'd0, 128'h3F800000_3F800000_3F800000_7F800001,
          128'h40000000_40000000_40000000_3F800000, 1'b0);
    check(res == 128'h3F800000_3F800000_3F800000_3F800000, "R9 result", res, 128'h3F800000_3F800000_3F800000_3F800000);
    check(inv_flag, "R9 flag set", {127'd0, inv_flag}, 128'd1);

    // R10 sticky across idle cycles
    repeat (3) @(negedge clk);
    check(inv_flag, "R10 sticky", {127'd0, inv_flag}, 128'd1);

    // R10 clear
    clr_inv = 1'b1;
    @(negedge clk);
    clr_inv = 1'b0;
    check(!inv_flag, "R10 clear", {127'd0, inv_flag}, '0);

    // R7 R9 signaling NaN quieted under NaN-propagating
    issue(1'b0, 1'b1, 2'd1, 128'h0_0_0_7F800001, 128'h0_0_0_3F800000, 1'b0);
    check(res[31:0] == 32'h7FC00001, "R7 quieted", res, 128'h7FC00001);
    check(inv_flag, "R9 flag under policy 1", {127'd0, inv_flag}, 128'd1);

    // R10 clear and new event in the same cycle; R8 returns op_b
    issue(1'b1, 1'b0, 2'd2, 128'h7FF00000_00000005_00000000_00000000,
          128'h3FF00000_00000000_80000000_00000000, 1'b1);
    check(res == 128'h3FF00000_00000000_80000000_00000000, "R8 double", res, 128'h3FF00000_00000000_80000000_00000000);
    check(inv_flag, "R10 set wins over clear", {127'd0, inv_flag}, 128'd1);

    // R2 single-lane sNaN pattern inside a double lane is not a NaN
    clr_inv = 1'b1;
    @(negedge clk);
    clr_inv = 1'b0;
    issue(1'b1, 1'b1, 2'd0, 128'h0_0_0_7F800001, 128'h0, 1'b0);
    check(res == 128'h0_0_0_7F800001, "R2 double interpretation", res, 128'h0_0_0_7F800001);
    check(!inv_flag, "R2 no flag in double lane", {127'd0, inv_flag}, '0);

    // R11 reset mid-run
    issue(1'b0, 1'b0, 2'd0, 128'h0_0_0_7F800001, 128'h0_0_0_3F800000, 1'b0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(res == '0 && !res_vld && !inv_flag, "R11 reset mid-run", res, '0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule